// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer

This block is a timing unit built around a 16-bit up-counter. A selectable prescaler divides the system clock by one of four ratios, and the counter advances once per prescaled tick. Software cannot load, clear or stop the counter. It starts from zero when reset is released, wraps after its largest value, and raises an overflow flag on each wrap.

Three dedicated channels capture the counter value when a chosen edge appears on their input pin. Four dedicated channels compare the counter against a stored value; on a match they raise a flag and can act on their output pin. An eighth channel works as either a capture or a compare channel, and its role is chosen by a mode bit.

Every channel has a flag and an interrupt enable, and so does the overflow. Each flag drives its own interrupt request line. A plain register write port loads the compare values and the configuration, and it clears flags by writing ones to their positions. The port accepts a write in every cycle it is presented and never stalls. No data interface here carries a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `ptm_timer`

## Requirements
- R1: The prescale select `presc_sel` sets how many clocks pass between counter advances: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. The counter advances by exactly one at each prescaled tick.
- R2: After reset the counter reads 0. All flags, interrupt requests, capture latches, compare pins and configuration fields also read 0. The counter first advances on the first prescaled tick after reset is released.
- R3: A tick while the counter holds 0xFFFF takes it to 0x0000, sets the overflow flag and lets counting continue. The overflow flag sits at bit 8 of the clear word and of the enable word.
- R4: No write at any address changes the counter. The counter keeps advancing one step per tick through any sequence of writes.
- R5: Address 7 holds 2 bits per capture channel k (0 to 3, where 3 is the dual channel) at bits [2k+1:2k]. Bit 2k enables the rising edge and bit 2k+1 enables the falling edge, so 00 disables the channel. Each pin passes through two synchronizer flops. A qualifying transition first sampled at clock edge n loads the latch at edge n+2 with the count held between edges n+1 and n+2. Transitions that are not enabled change nothing.
- R6: Flag bit positions are: 0 to 2 for the dedicated capture channels, 3 to 6 for the dedicated compare channels, 7 for the dual channel and 8 for overflow. A capture event sets its flag on the same edge that loads the latch.
- R7: Addresses 0 to 3 hold the dedicated compare values. When a tick arrives while the counter equals a channel's value, that edge sets the flag and applies the pin action, and the counter then shows value+1. Address 8 holds 2 action bits per compare channel j (0 to 4, where 4 is the dual channel) at bits [2j+1:2j]: 00 leaves the pin unchanged, 01 toggles it, 10 drives it low and 11 drives it high.
- R8: Bit 0 of address 9 selects the role of the dual channel: 0 means capture from `cap_in[3]`, and 1 means compare driving `cmp_out[4]`. The dual channel uses a single 16-bit register, written at address 4 and visible on `cap_val[63:48]`. In compare mode, edges on `cap_in[3]` have no effect.
- R9: Writing address 5 clears every flag whose data bit is 1 and leaves flags under 0 bits unchanged. A set event in the same cycle wins over a clear.
- R10: Address 6 holds the interrupt enables in the same bit layout as the flags. Each request line equals its flag AND its enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_sel | input | 2 | Prescale ratio select |
| cap_in | input | 4 | Capture pins; bit 3 feeds the dual channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| count | output | 16 | Free-running counter value |
| cap_val | output | 64 | Capture latches, 16 bits each; the top slice is the dual channel register |
| cmp_out | output | 5 | Compare pins; bit 4 is the dual channel |
| ch_flag | output | 8 | Channel flags |
| ovf_flag | output | 1 | Overflow flag |
| ch_irq | output | 8 | Channel interrupt requests |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
Some rules are checked by assertions on every cycle: the counter and the prescaler never skip or repeat a tick, a wrap sets the overflow flag, a latch or a compare pin never changes without its own event, set wins over clear, and the dual channel never captures while it is in compare mode. The bench scenarios cover what depends on exact numbers. These are the measured tick spacing for each ratio, the count a capture latches after the synchronizer delay, the counter value shown when a compare fires, each pin action, the dual channel's change of role, and the enable gating of the interrupt lines.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  localparam int NUM_CAP = 3;
  localparam int NUM_CMP = 4;
  localparam int NCH     = NUM_CAP + NUM_CMP + 1;
  localparam int NFLG    = NCH + 1;
  localparam int PRE_W   = 5;

  localparam int ADR_DUAL = NUM_CMP;
  localparam int ADR_CLR  = 5;
  localparam int ADR_IEN  = 6;
  localparam int ADR_EDGE = 7;
  localparam int ADR_ACT  = 8;
  localparam int ADR_MODE = 9;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_LOW    = 2'b10,
    ACT_HIGH   = 2'b11
  } cmp_act_e;

  function automatic logic [PRE_W-1:0] presc_ratio(input logic [1:0] sel);
    case (sel)
      2'b00:   presc_ratio = PRE_W'(1);
      2'b01:   presc_ratio = PRE_W'(4);
      2'b10:   presc_ratio = PRE_W'(8);
      default: presc_ratio = PRE_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/ptm_timebase.sv
module ptm_timebase
  import ptm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   sel,
  output logic [W-1:0] count,
  output logic         tick,
  output logic         wrap
);
  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] lim;

  // ">=" lets a shorter ratio take effect at once after a select change
  assign lim  = presc_ratio(sel) - PRE_W'(1);
  assign tick = (div_q >= lim);
  assign wrap = tick && (count == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      count <= '0;
    end else if (tick) begin
      div_q <= '0;
      count <= count + W'(1);
    end else begin
      div_q <= div_q + PRE_W'(1);
    end
  end

  a_r1_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != 2'b00) |=> (!tick || sel == 2'b00));

  a_r4_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));

  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0));
endmodule

// File: rtl/ptm_capture.sv
module ptm_capture #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         pin,
  input  logic [1:0]   edge_sel,
  input  logic [W-1:0] count,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] val,
  output logic         evt
);
  logic s1, s2, s3;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= pin;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 && !s3;
  assign fall = !s2 && s3;
  assign evt  = en && ((edge_sel[0] && rise) || (edge_sel[1] && fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val <= '0;
    else if (evt)  val <= count;
    else if (load) val <= load_val;
  end

  a_r5_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !load) |=> $stable(val));

  a_r5_capture_takes_count: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (val == $past(count)));
endmodule

// File: rtl/ptm_compare.sv
module ptm_compare
  import ptm_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] count,
  input  logic [W-1:0] ref_val,
  input  logic [1:0]   act,
  output logic         pin,
  output logic         evt
);
  assign evt = en && tick && (count == ref_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= 1'b0;
    end else if (evt) begin
      case (cmp_act_e'(act))
        ACT_TOGGLE: pin <= !pin;
        ACT_LOW:    pin <= 1'b0;
        ACT_HIGH:   pin <= 1'b1;
        default:    pin <= pin;
      endcase
    end
  end

  a_r7_pin_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(pin));

  a_r7_drive_high: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && act == ACT_HIGH) |=> pin);

  a_r7_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && act == ACT_TOGGLE) |=> (pin != $past(pin)));
endmodule

// File: rtl/ptm_flags.sv
module ptm_flags #(
  parameter int N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flag,
  output logic [N-1:0] irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= '0;
    else        flag <= (flag & ~clr) | set;
  end

  assign irq = flag & ien;

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> flag[i]);
    a_r9_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flag[i]);
  end
endmodule

// File: rtl/ptm_timer.sv
module ptm_timer
  import ptm_pkg::*;
#(
  parameter int W      = 16,
  parameter int ADDR_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               presc_sel,
  input  logic [NUM_CAP:0]         cap_in,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [W-1:0]             wr_data,
  output logic [W-1:0]             count,
  output logic [(NUM_CAP+1)*W-1:0] cap_val,
  output logic [NUM_CMP:0]         cmp_out,
  output logic [NCH-1:0]           ch_flag,
  output logic                     ovf_flag,
  output logic [NCH-1:0]           ch_irq,
  output logic                     ovf_irq
);
  localparam int EDGE_W = 2 * (NUM_CAP + 1);
  localparam int ACT_W  = 2 * (NUM_CMP + 1);

  logic              tick, wrap;
  logic [W-1:0]      cmp_reg [NUM_CMP];
  logic [EDGE_W-1:0] edge_cfg;
  logic [ACT_W-1:0]  act_cfg;
  logic [NFLG-1:0]   ien;
  logic              dual_cmp;
  logic              dual_wr;
  logic [NFLG-1:0]   clr;
  logic [NFLG-1:0]   set;
  logic [NFLG-1:0]   flag, irq;
  logic [NUM_CAP:0]  cap_evt;
  logic [NUM_CMP:0]  cmp_evt;
  logic [W-1:0]      dual_val;

  ptm_timebase #(.W(W)) u_tb (
    .clk(clk), .rst_n(rst_n), .sel(presc_sel),
    .count(count), .tick(tick), .wrap(wrap)
  );

  // register port: one write per cycle, never stalls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_CMP; k++) cmp_reg[k] <= '0;
      edge_cfg <= '0;
      act_cfg  <= '0;
      ien      <= '0;
      dual_cmp <= 1'b0;
    end else if (wr_en) begin
      for (int k = 0; k < NUM_CMP; k++)
        if (wr_addr == ADDR_W'(k)) cmp_reg[k] <= wr_data;
      if (wr_addr == ADDR_W'(ADR_EDGE)) edge_cfg <= wr_data[EDGE_W-1:0];
      if (wr_addr == ADDR_W'(ADR_ACT))  act_cfg  <= wr_data[ACT_W-1:0];
      if (wr_addr == ADDR_W'(ADR_IEN))  ien      <= wr_data[NFLG-1:0];
      if (wr_addr == ADDR_W'(ADR_MODE)) dual_cmp <= wr_data[0];
    end
  end

  assign dual_wr = wr_en && (wr_addr == ADDR_W'(ADR_DUAL));
  assign clr     = (wr_en && wr_addr == ADDR_W'(ADR_CLR)) ? wr_data[NFLG-1:0] : '0;

  for (genvar gi = 0; gi <= NUM_CAP; gi++) begin : g_cap
    logic         en_c, ld_c;
    logic [W-1:0] lv_c, val_c;
    if (gi == NUM_CAP) begin : g_dual
      assign en_c = !dual_cmp;
      assign ld_c = dual_wr;
      assign lv_c = wr_data;
    end else begin : g_ded
      assign en_c = 1'b1;
      assign ld_c = 1'b0;
      assign lv_c = '0;
    end
    ptm_capture #(.W(W)) u_cap (
      .clk(clk), .rst_n(rst_n), .en(en_c), .pin(cap_in[gi]),
      .edge_sel(edge_cfg[2*gi +: 2]), .count(count),
      .load(ld_c), .load_val(lv_c), .val(val_c), .evt(cap_evt[gi])
    );
    assign cap_val[gi*W +: W] = val_c;
  end

  assign dual_val = cap_val[NUM_CAP*W +: W];

  for (genvar gj = 0; gj <= NUM_CMP; gj++) begin : g_cmp
    logic         en_o;
    logic [W-1:0] ref_o;
    if (gj == NUM_CMP) begin : g_dual
      assign en_o  = dual_cmp;
      assign ref_o = dual_val;
    end else begin : g_ded
      assign en_o  = 1'b1;
      assign ref_o = cmp_reg[gj];
    end
    ptm_compare #(.W(W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .en(en_o), .tick(tick), .count(count),
      .ref_val(ref_o), .act(act_cfg[2*gj +: 2]),
      .pin(cmp_out[gj]), .evt(cmp_evt[gj])
    );
  end

  always_comb begin
    set = '0;
    for (int k = 0; k < NUM_CAP; k++) set[k] = cap_evt[k];
    for (int k = 0; k < NUM_CMP; k++) set[NUM_CAP + k] = cmp_evt[k];
    set[NCH-1] = cap_evt[NUM_CAP] | cmp_evt[NUM_CMP];
    set[NCH]   = wrap;
  end

  ptm_flags #(.N(NFLG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(set), .clr(clr), .ien(ien),
    .flag(flag), .irq(irq)
  );

  assign ch_flag  = flag[NCH-1:0];
  assign ovf_flag = flag[NCH];
  assign ch_irq   = irq[NCH-1:0];
  assign ovf_irq  = irq[NCH];

  a_r3_wrap_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> ovf_flag);

  a_r8_no_capture_in_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    dual_cmp |-> !cap_evt[NUM_CAP]);

  a_r8_no_compare_in_cap: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_cmp |-> !cmp_evt[NUM_CMP]);
endmodule

// File: tb/ptm_timer_bench.sv
module ptm_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  presc_sel = 2'b00;
  logic [3:0]  cap_in = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [63:0] cap_val;
  logic [4:0]  cmp_out;
  logic [7:0]  ch_flag;
  logic        ovf_flag;
  logic [7:0]  ch_irq;
  logic        ovf_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptm_timer u_ptm_timer (
    .clk(clk), .rst_n(rst_n), .presc_sel(presc_sel), .cap_in(cap_in),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .cap_val(cap_val), .cmp_out(cmp_out),
    .ch_flag(ch_flag), .ovf_flag(ovf_flag), .ch_irq(ch_irq), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] capv(input int k);
    return cap_val[k*16 +: 16];
  endfunction

  task automatic cap_drive(input int k, input logic lvl, output logic [15:0] exp);
    cap_in[k] = lvl;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exp = count;
    step();
  endtask

  task automatic wait_flag(input int b);
    for (int n = 0; n < 400 && !ch_flag[b]; n++) step();
  endtask

  task automatic t_reset();
    chk("R2", "count after reset", 32'(count), 32'h0);
    chk("R2", "flags after reset", {ch_flag, ovf_flag}, 9'h0);
    chk("R2", "irqs after reset", {ch_irq, ovf_irq}, 9'h0);
    chk("R2", "pins and latches after reset", {cmp_out, cap_val}, 69'h0);
    step();
    chk("R2", "first advance", 32'(count), 32'h1);
  endtask

  task automatic t_prescale();
    int ratio [4] = '{1, 4, 8, 16};
    for (int s = 0; s < 4; s++) begin
      logic [15:0] cur;
      int n;
      presc_sel = 2'(s);
      cur = count;
      for (int k = 0; k < 40 && count == cur; k++) step();
      cur = count;
      n = 0;
      do begin step(); n++; end while (count == cur && n < 40);
      chk("R1", $sformatf("clocks per tick sel=%0d", s), n, ratio[s]);
      chk("R1", "advance by one", 32'(count - cur), 32'h1);
    end
    presc_sel = 2'b00;
    step();
  endtask

  task automatic t_no_counter_write();
    logic [15:0] c0 = count;
    for (int a = 10; a < 16; a++) wr(a, 16'hFFFF);
    wr(5, 16'h0000);
    chk("R4", "counter unaffected by writes", 32'(count), 32'(c0 + 16'd7));
  endtask

  task automatic t_capture();
    logic [15:0] e, v1;
    wr(7, 16'h0039);
    wr(5, 16'h01FF);
    cap_drive(0, 1'b1, e);
    chk("R5", "rising capture ch0", 32'(capv(0)), 32'(e));
    chk("R6", "ch0 flag set", 32'(ch_flag[0]), 32'h1);
    wr(5, 16'h0001);
    v1 = capv(0);
    cap_drive(0, 1'b0, e);
    chk("R5", "falling ignored on ch0", {ch_flag[0], capv(0)}, {1'b0, v1});
    cap_drive(1, 1'b1, e);
    chk("R5", "rising ignored on ch1", {ch_flag[1], capv(1)}, 17'h0);
    cap_drive(1, 1'b0, e);
    chk("R5", "falling capture ch1", {ch_flag[1], capv(1)}, {1'b1, e});
    cap_drive(2, 1'b1, e);
    chk("R5", "both-edge rise ch2", {ch_flag[2], capv(2)}, {1'b1, e});
    cap_drive(2, 1'b0, e);
    chk("R5", "both-edge fall ch2", 32'(capv(2)), 32'(e));
    cap_drive(3, 1'b1, e);
    chk("R5", "disabled dual capture", {ch_flag[7], capv(3)}, 17'h0);
    cap_in[3] = 1'b0;
    step(); step(); step();
  endtask

  task automatic t_clear_irq();
    wr(5, 16'h0004);
    chk("R9", "only written bit cleared", 32'(ch_flag[2:0]), 32'h2);
    wr(6, 16'h0006);
    chk("R10", "irq gated by flag and enable", 32'(ch_irq[2:0]), 32'h2);
    wr(6, 16'h0000);
    chk("R10", "irq off when disabled", 32'(ch_irq), 32'h0);
  endtask

  task automatic t_compare();
    logic [15:0] c;
    presc_sel = 2'b00;
    wr(8, 16'h0007);
    wr(5, 16'h01FF);
    c = count;
    wr(0, c + 16'd30);
    wr(1, c + 16'd40);
    chk("R7", "pin idle before match", 32'(cmp_out[1:0]), 32'h0);
    wait_flag(3);
    chk("R7", "count at ch0 match", 32'(count), 32'(c + 16'd31));
    chk("R7", "high action and toggle pending", 32'(cmp_out[1:0]), 32'h1);
    wait_flag(4);
    chk("R7", "count at ch1 match", 32'(count), 32'(c + 16'd41));
    chk("R7", "toggle action ch1", 32'(cmp_out[1]), 32'h1);
    wr(8, 16'h0006);
    wr(5, 16'h0008);
    wr(0, count + 16'd10);
    wait_flag(3);
    chk("R7", "low action ch0", {ch_flag[3], cmp_out[0]}, 2'b10);
    presc_sel = 2'b01;
    c = count;
    for (int k = 0; k < 20 && count == c; k++) step();
    wr(5, 16'h0020);
    c = count;
    wr(2, c + 16'd3);
    wait_flag(5);
    chk("R7", "prescaled match count", 32'(count), 32'(c + 16'd4));
    chk("R7", "none action leaves pin", 32'(cmp_out[2]), 32'h0);
    presc_sel = 2'b00;
    step();
  endtask

  task automatic t_dual();
    logic [15:0] e, c;
    wr(7, 16'h0079);
    wr(5, 16'h0080);
    cap_drive(3, 1'b1, e);
    chk("R8", "dual capture mode latch", {ch_flag[7], capv(3)}, {1'b1, e});
    cap_in[3] = 1'b0;
    step(); step(); step();
    wr(4, 16'h1234);
    chk("R8", "dual register write", 32'(capv(3)), 32'h1234);
    chk("R8", "no compare while capturing", 32'(cmp_out[4]), 32'h0);
    wr(9, 16'h0001);
    wr(8, 16'h0300);
    wr(5, 16'h0080);
    c = count;
    wr(4, c + 16'd20);
    wait_flag(7);
    chk("R8", "dual compare count", 32'(count), 32'(c + 16'd21));
    chk("R8", "dual compare pin high", 32'(cmp_out[4]), 32'h1);
    wr(5, 16'h0080);
    cap_drive(3, 1'b1, e);
    chk("R8", "capture ignored in compare mode", {ch_flag[7], capv(3)}, {1'b0, c + 16'd20});
  endtask

  task automatic t_overflow();
    presc_sel = 2'b00;
    wr(5, 16'h0100);
    chk("R3", "overflow clear", 32'(ovf_flag), 32'h0);
    for (int k = 0; k < 70000 && count != 16'hFFFF; k++) step();
    step();
    chk("R3", "wrap to zero", 32'(count), 32'h0);
    chk("R3", "overflow flag set", 32'(ovf_flag), 32'h1);
    step();
    chk("R3", "keeps counting", 32'(count), 32'h1);
    wr(6, 16'h0100);
    chk("R10", "overflow irq", 32'(ovf_irq), 32'h1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_prescale();
    t_no_counter_write();
    t_capture();
    t_clear_irq();
    t_compare();
    t_dual();
    t_overflow();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule